// File: doc/BRIEF.md
# Two-Channel Subband Split and Rebuild Filter Bank

This block takes a stream of signed 16-bit samples and splits it into a low-frequency branch and a high-frequency branch, each at half the input rate. It then rebuilds a full-rate stream from the two branches. Each accepted input is first clamped to an 11-bit signed range. It then passes through two analysis FIRs. Only every second filter result is kept, so the filter runs before the discard. The kept results leave the block as a pair of subband samples with their own strobe.

On the synthesis side, each branch pushes its subband sample into a delay line and then pushes a zero after it. Each delay line feeds its own interpolation FIR, and the two FIR sums are added. The total is rounded to nearest with a fixed right shift and saturated to 16 bits. Coefficients are compile-time parameters.

The default set is a two-tap orthogonal pair: low analysis {1,1}, high analysis {1,-1}, low synthesis {1,1}, high synthesis {-1,1}, with a shift of one. With these defaults each output sample equals the clamped input from one sample earlier.

Top module: `qmf_bank`

## Requirements
- R1: On acceptance, an input above +1023 is replaced by +1023 and an input below -1024 is replaced by -1024, so out-of-range input never wraps. In-range values pass through unchanged.
- R2: All data are two's complement, so negative inputs such as -1 and -1024 appear with the same sign and value in the subbands and in the output.
- R3: The low subband sample is the low analysis FIR applied to the clamped input history, with tap 0 the newest sample. With the default coefficients, the value kept at accepted sample 2m is c[2m]+c[2m-1], taking the clamped history before reset as 0.
- R4: The high subband sample is the high analysis FIR on the same history. With the default coefficients it is c[2m]-c[2m-1].
- R5: `sb_valid` pulses for one cycle once for every two accepted inputs. The first pulse belongs to the first input after reset, then the third, the fifth and so on. It is never high on two consecutive cycles.
- R6: Each synthesis branch inserts its subband sample and then a zero, and filters the result. The two branch sums are added, rounded as (sum + 2^(S-1)) >> S with S = 1, and saturated to 16 bits. With the defaults, output n equals the clamped input n-1 (latency of one sample).
- R7: Every accepted input produces exactly one output, with `out_valid` high exactly 4 clock cycles after the cycle in which `in_valid` was sampled high.
- R8: While `rst` is high, `out_valid`, `sb_valid` and `out_data` are 0. After reset the sample history is zero and the keep/discard phase restarts.
- R9: Cycles with `in_valid` low do not advance the filters or the phase, so gaps of any length between inputs leave all results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Rebuilt sample qualifier |
| out_data | output | 16 | Rebuilt signed sample, rounded and saturated |
| sb_valid | output | 1 | Subband pair qualifier, half rate |
| sb_low | output | 16 | Low-band subband sample |
| sb_high | output | 16 | High-band subband sample |

## Verification
Suppose the keep/discard phase slipped by one. The subband pair for the next strobe would pair the wrong two samples. The rebuilt output would then stop matching the delayed input within one or two samples. A stale or unshifted history tap shows up as the wrong sum or difference on the very next subband strobe. A missing zero in a synthesis line corrupts the output two samples after the fault. An impulse makes each of these visible as a specific wrong value. A long random stream with gaps, out-of-range values and a mid-stream reset covers the phase and history cases.

// File: rtl/qmf_pkg.sv
package qmf_pkg;
  // Keep/discard phase of the half-rate decimator
  typedef enum logic {PH_KEEP = 1'b0, PH_DROP = 1'b1} phase_e;
endpackage

// File: rtl/qmf_analysis.sv
module qmf_analysis
  import qmf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 11,
  parameter int COEF_W = 4,
  parameter int NTAPS  = 2,
  parameter int SB_W   = 16,
  parameter int H0 [NTAPS] = '{1, 1},
  parameter int H1 [NTAPS] = '{1, -1}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     sb_valid,
  output logic signed [SB_W-1:0]   sb_low,
  output logic signed [SB_W-1:0]   sb_high,
  output logic                     step
);
  localparam int HI = 2**(IN_W-1) - 1;
  localparam int LO = -(2**(IN_W-1));

  logic signed [IN_W-1:0] taps [NTAPS];
  logic signed [IN_W-1:0] clamped;
  logic                   pend;
  phase_e                 ph, ph_q;
  logic signed [SB_W-1:0] acc_l, acc_h;

  // Range clamp ahead of the filters (saturate, never wrap)
  always_comb begin
    if (in_data > DATA_W'(HI))      clamped = IN_W'(HI);
    else if (in_data < DATA_W'(LO)) clamped = IN_W'(LO);
    else                            clamped = in_data[IN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
      pend <= 1'b0;
      ph   <= PH_KEEP;
      ph_q <= PH_KEEP;
    end else begin
      pend <= in_valid;
      if (in_valid) begin
        for (int k = NTAPS-1; k > 0; k--) taps[k] <= taps[k-1];
        taps[0] <= clamped;
        ph_q    <= ph;
        ph      <= (ph == PH_KEEP) ? PH_DROP : PH_KEEP;
      end
    end
  end

  // Full-rate FIR sums; only the kept phase is registered
  always_comb begin
    logic signed [COEF_W-1:0] c0, c1;
    acc_l = '0;
    acc_h = '0;
    for (int k = 0; k < NTAPS; k++) begin
      c0 = COEF_W'(H0[k]);
      c1 = COEF_W'(H1[k]);
      acc_l = acc_l + SB_W'(taps[k]) * SB_W'(c0);
      acc_h = acc_h + SB_W'(taps[k]) * SB_W'(c1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_valid <= 1'b0;
      sb_low   <= '0;
      sb_high  <= '0;
      step     <= 1'b0;
    end else begin
      step     <= pend;
      sb_valid <= pend && (ph_q == PH_KEEP);
      if (pend && (ph_q == PH_KEEP)) begin
        sb_low  <= acc_l;
        sb_high <= acc_h;
      end
    end
  end

  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    sb_valid |=> !sb_valid);
  a_r1_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data > DATA_W'(HI)) |=> (taps[0] == IN_W'(HI)));
  a_r1_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data < DATA_W'(LO)) |=> (taps[0] == IN_W'(LO)));
endmodule

// File: rtl/qmf_synth_branch.sv
module qmf_synth_branch #(
  parameter int SB_W   = 16,
  parameter int COEF_W = 4,
  parameter int NTAPS  = 2,
  parameter int BR_W   = 21,
  parameter int G [NTAPS] = '{1, 1}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step,
  input  logic                   keep,
  input  logic signed [SB_W-1:0] sb_in,
  output logic                   out_step,
  output logic signed [BR_W-1:0] br_sum
);
  logic signed [SB_W-1:0] line [NTAPS];

  // Zero-stuff: subband value on kept phase, zero otherwise
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) line[k] <= '0;
      out_step <= 1'b0;
    end else begin
      out_step <= step;
      if (step) begin
        for (int k = NTAPS-1; k > 0; k--) line[k] <= line[k-1];
        line[0] <= keep ? sb_in : '0;
      end
    end
  end

  always_comb begin
    logic signed [COEF_W-1:0] cg;
    br_sum = '0;
    for (int k = 0; k < NTAPS; k++) begin
      cg = COEF_W'(G[k]);
      br_sum = br_sum + BR_W'(line[k]) * BR_W'(cg);
    end
  end

  a_r6_zero_stuff: assert property (@(posedge clk) disable iff (rst)
    (step && !keep) |=> (line[0] == '0));
endmodule

// File: rtl/qmf_bank.sv
module qmf_bank #(
  parameter int DATA_W    = 16,
  parameter int IN_W      = 11,
  parameter int COEF_W    = 4,
  parameter int NTAPS     = 2,
  parameter int OUT_SHIFT = 1,
  parameter int H0 [NTAPS] = '{1, 1},
  parameter int H1 [NTAPS] = '{1, -1},
  parameter int G0 [NTAPS] = '{1, 1},
  parameter int G1 [NTAPS] = '{-1, 1},
  localparam int SB_W  = IN_W + COEF_W + $clog2(NTAPS),
  localparam int BR_W  = SB_W + COEF_W + $clog2(NTAPS),
  localparam int ACC_W = BR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     sb_valid,
  output logic signed [SB_W-1:0]   sb_low,
  output logic signed [SB_W-1:0]   sb_high
);
  localparam longint OMAX = (64'sd1 <<< (DATA_W-1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (DATA_W-1));
  localparam longint RND  = (OUT_SHIFT > 0) ? (64'sd1 <<< (OUT_SHIFT-1)) : 0;
  localparam int     LAT_SAMPLES = NTAPS - 1;

  logic                    step, st0, st1;
  logic signed [BR_W-1:0]  br0, br1;
  logic signed [ACC_W-1:0] tot, rnd;
  logic signed [DATA_W-1:0] sat;

  qmf_analysis #(
    .DATA_W(DATA_W), .IN_W(IN_W), .COEF_W(COEF_W), .NTAPS(NTAPS),
    .SB_W(SB_W), .H0(H0), .H1(H1)
  ) u_ana (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .sb_valid(sb_valid), .sb_low(sb_low), .sb_high(sb_high), .step(step)
  );

  qmf_synth_branch #(
    .SB_W(SB_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .BR_W(BR_W), .G(G0)
  ) u_syn_lo (
    .clk(clk), .rst(rst), .step(step), .keep(sb_valid), .sb_in(sb_low),
    .out_step(st0), .br_sum(br0)
  );

  qmf_synth_branch #(
    .SB_W(SB_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .BR_W(BR_W), .G(G1)
  ) u_syn_hi (
    .clk(clk), .rst(rst), .step(step), .keep(sb_valid), .sb_in(sb_high),
    .out_step(st1), .br_sum(br1)
  );

  // Branch sum, round to nearest, saturate
  always_comb begin
    tot = ACC_W'(br0) + ACC_W'(br1);
    rnd = (tot + ACC_W'(RND)) >>> OUT_SHIFT;
    if (rnd > ACC_W'(OMAX))      sat = DATA_W'(OMAX);
    else if (rnd < ACC_W'(OMIN)) sat = DATA_W'(OMIN);
    else                         sat = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= st0;
      if (st0) out_data <= sat;
    end
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 out_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4));
  a_r6_branches_in_step: assert property (@(posedge clk) disable iff (rst)
    st0 == st1);
endmodule

// File: tb/tb_qmf_bank.sv
module tb_qmf_bank;
  localparam int SB_W = 16;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic signed [15:0] in_data = '0;
  logic out_valid, sb_valid;
  logic signed [15:0] out_data;
  logic signed [SB_W-1:0] sb_low, sb_high;

  qmf_bank dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .sb_valid(sb_valid), .sb_low(sb_low), .sb_high(sb_high)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int q_out[$], q_lo[$], q_hi[$], q_t[$];
  int prev_c = 0;
  bit ph = 0;
  bit last_sb = 0;
  string tag = "R6";

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampv(int x);
    if (x > 1023) return 1023;
    if (x < -1024) return -1024;
    return x;
  endfunction

  // Driver: present one sample and record expectations
  task automatic send(int x);
    int c;
    @(negedge clk);
    in_valid = 1;
    in_data  = 16'(x);
    c = clampv(x);
    q_out.push_back(prev_c);
    q_t.push_back(cyc);
    if (!ph) begin
      q_lo.push_back(c + prev_c);
      q_hi.push_back(c - prev_c);
    end
    ph = ~ph;
    prev_c = c;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(sb_valid == 0, "R8", "sb_valid in reset", int'(sb_valid), 0);
    check(out_data == 0, "R8", "out_data in reset", int'(out_data), 0);
    q_out.delete(); q_lo.delete(); q_hi.delete(); q_t.delete();
    prev_c = 0; ph = 0; last_sb = 0;
    rst = 0;
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q_out.size() == 0) check(0, "R7", "unexpected output", 1, 0);
        else begin
          int e, t;
          e = q_out.pop_front();
          t = q_t.pop_front();
          check(int'(out_data) == e, tag, "rebuilt output", int'(out_data), e);
          check(cyc - t == 4, "R7", "output latency", cyc - t, 4);
        end
      end
      if (sb_valid) begin
        check(!last_sb, "R5", "strobe on consecutive cycles", 1, 0);
        if (q_lo.size() == 0) check(0, "R5", "unexpected subband strobe", 1, 0);
        else begin
          int el, eh;
          el = q_lo.pop_front();
          eh = q_hi.pop_front();
          check(int'(sb_low) == el, "R3", "low subband", int'(sb_low), el);
          check(int'(sb_high) == eh, "R4", "high subband", int'(sb_high), eh);
        end
      end
      last_sb = sb_valid;
    end
  end

  task automatic drain(string req);
    idle(8);
    check(q_out.size() == 0, req, "outputs outstanding", q_out.size(), 0);
    check(q_lo.size() == 0, "R5", "subbands outstanding", q_lo.size(), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();

    // Impulse, back-to-back
    tag = "R6 impulse";
    send(1000);
    for (int i = 0; i < 6; i++) send(0);
    drain("R7");

    // Negative two's complement values
    tag = "R2 negative";
    send(-1); send(-1024); send(-500); send(7); send(-3); send(0);
    drain("R2");

    // Out-of-range values saturate
    tag = "R1 clamp";
    send(5000); send(-5000); send(32767); send(-32768);
    send(1023); send(1024); send(-1024); send(-1025); send(0);
    drain("R1");

    // Random stream with random gaps
    tag = "R9 gapped random";
    for (int i = 0; i < 300; i++) begin
      send($signed($urandom_range(0, 8191)) - 4096);
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 5));
    end
    drain("R9");

    // Reset after an odd count restarts phase and history
    tag = "R8 restart";
    send(300); send(-200); send(100);
    idle(1);
    do_reset();
    send(50); send(60); send(-70); send(80);
    drain("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule